// File: doc/BRIEF.md
# Operand Effective Address Generator

This block works out where an instruction's operand lives for a small 8-bit processor with a 16-bit (64 KiB) address space. Each cycle in which `insn_valid` is high, it takes a 3-bit addressing-mode code and the operand bytes that have already been fetched through the program counter. One clock edge later it presents four results: the effective address, whether a data-memory access is needed, how many operand bytes the program counter must step over, and whether the mode code is illegal.

The block supports five modes: immediate, register, page zero, movable direct page and long direct. In direct-page mode, an internal 8-bit page register supplies the upper address byte and the single operand byte supplies the lower one. Software loads the page register through `dp_wr_en`/`dp_wr_data`. The block also models how a register read behaves: index zero always reads as constant zero.

Top module: `opnd_addr_gen`

## Requirements
- R1: Results appear on the clock edge after a cycle with `insn_valid` high, with `out_valid` high for exactly that one cycle. `out_valid` is low in every cycle whose previous cycle had `insn_valid` low.
- R2: Register mode (code 3'b001) gives `mem_access`=0, `eff_addr`=0x0000 and `opnd_bytes`=0.
- R3: `rdata` is zero whenever the captured `rsel` is 0, whatever `rdata_raw` holds. For any other index, `rdata` equals the captured `rdata_raw`.
- R4: Immediate mode (code 3'b000) gives `opnd_bytes`=1, `mem_access`=0 and `eff_addr`=0x0000.
- R5: Page-zero mode (code 3'b010) gives `eff_addr`={8'h00, `opnd_b0`}, `mem_access`=1 and `opnd_bytes`=1.
- R6: Direct-page mode (code 3'b011) gives `eff_addr`={page register, `opnd_b0`}, `mem_access`=1 and `opnd_bytes`=1.
- R7: Long direct mode (code 3'b100) gives `eff_addr`={`opnd_b0`, `opnd_b1`}, with the first-fetched byte `opnd_b0` as the high byte. It also gives `mem_access`=1 and `opnd_bytes`=2.
- R8: Mode codes 3'b101, 3'b110 and 3'b111 give `illegal_mode`=1, `mem_access`=0, `eff_addr`=0x0000 and `opnd_bytes`=0. Every legal code gives `illegal_mode`=0.
- R9: The page register resets to 0x00. Until it is written, direct-page mode gives the same address as page-zero mode.
- R10: A page-register write in the same cycle as an instruction does not affect that instruction's address. It applies from the next instruction onward. The register holds its value when `dp_wr_en` is low.
- R11: During and directly after reset, `out_valid`, `eff_addr`, `mem_access`, `opnd_bytes`, `illegal_mode` and `rdata` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_valid | input | 1 | Operand fields are valid this cycle |
| mode | input | 3 | Addressing-mode code |
| opnd_b0 | input | 8 | First operand byte fetched |
| opnd_b1 | input | 8 | Second operand byte fetched (long direct only) |
| dp_wr_en | input | 1 | Load the direct-page register |
| dp_wr_data | input | 8 | New direct-page value |
| rsel | input | RIDX_W | Register index being read |
| rdata_raw | input | REG_W | Raw register-file read data |
| out_valid | output | 1 | Results below are valid |
| eff_addr | output | 16 | Effective address |
| mem_access | output | 1 | A data-memory access is required |
| opnd_bytes | output | 2 | Operand bytes consumed by the program counter |
| illegal_mode | output | 1 | Mode code is not defined |
| rdata | output | REG_W | Register read data with index zero forced to zero |

## Verification
The hardest case to reach from the ports is a page-register write that falls in the same cycle as a direct-page instruction. There, the old value must be used, and the next instruction must see the new one. The random stimulus asserts `dp_wr_en` on about a third of its vectors, independently of the mode, so same-cycle collisions occur often. A directed sequence also places a write exactly on a direct-page instruction and follows it with a second direct-page instruction. The bench's own copy of the page register is updated only after each expected value has been computed.

// File: rtl/oeag_pkg.sv
package oeag_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 2 * BYTE_W;
  localparam int CNT_W  = 2;

  typedef enum logic [2:0] {
    AM_IMM  = 3'd0,
    AM_REG  = 3'd1,
    AM_PG0  = 3'd2,
    AM_DPG  = 3'd3,
    AM_LONG = 3'd4
  } amode_e;

  function automatic logic mode_is_legal(input logic [2:0] m);
    return m <= 3'd4;
  endfunction

  function automatic logic [ADDR_W-1:0] form_addr(input logic [2:0] m,
                                                 input logic [BYTE_W-1:0] b0,
                                                 input logic [BYTE_W-1:0] b1,
                                                 input logic [BYTE_W-1:0] page);
    logic [ADDR_W-1:0] a;
    a = '0;
    if (m == AM_PG0)       a = {{BYTE_W{1'b0}}, b0};
    else if (m == AM_DPG)  a = {page, b0};
    else if (m == AM_LONG) a = {b0, b1};
    return a;
  endfunction

  function automatic logic needs_memory(input logic [2:0] m);
    return (m == AM_PG0) || (m == AM_DPG) || (m == AM_LONG);
  endfunction

  function automatic logic [CNT_W-1:0] operand_len(input logic [2:0] m);
    logic [CNT_W-1:0] n;
    n = '0;
    if (m == AM_IMM || m == AM_PG0 || m == AM_DPG) n = 2'd1;
    else if (m == AM_LONG)                         n = 2'd2;
    return n;
  endfunction
endpackage

// File: rtl/oeag_dp_reg.sv
module oeag_dp_reg
  import oeag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] page
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     page <= '0;
    else if (wr_en) page <= wr_data;
  end
endmodule

// File: rtl/oeag_zero_reg.sv
module oeag_zero_reg #(
  parameter int RIDX_W = 4,
  parameter int REG_W  = 8
) (
  input  logic [RIDX_W-1:0] idx,
  input  logic [REG_W-1:0]  raw,
  output logic [REG_W-1:0]  value,
  output logic              is_zero_idx
);
  always_comb begin
    is_zero_idx = (idx == '0);
    value       = is_zero_idx ? '0 : raw;
  end
endmodule

// File: rtl/oeag_ea_calc.sv
module oeag_ea_calc
  import oeag_pkg::*;
(
  input  logic [2:0]        mode,
  input  logic [BYTE_W-1:0] b0,
  input  logic [BYTE_W-1:0] b1,
  input  logic [BYTE_W-1:0] page,
  output logic [ADDR_W-1:0] ea,
  output logic              mem,
  output logic [CNT_W-1:0]  nbytes,
  output logic              bad_mode
);
  always_comb begin
    bad_mode = !mode_is_legal(mode);
    ea       = form_addr(mode, b0, b1, page);
    mem      = needs_memory(mode);
    nbytes   = operand_len(mode);
  end
endmodule

// File: rtl/opnd_addr_gen.sv
module opnd_addr_gen
  import oeag_pkg::*;
#(
  parameter int RIDX_W = 4,
  parameter int REG_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              insn_valid,
  input  logic [2:0]        mode,
  input  logic [7:0]        opnd_b0,
  input  logic [7:0]        opnd_b1,
  input  logic              dp_wr_en,
  input  logic [7:0]        dp_wr_data,
  input  logic [RIDX_W-1:0] rsel,
  input  logic [REG_W-1:0]  rdata_raw,
  output logic              out_valid,
  output logic [15:0]       eff_addr,
  output logic              mem_access,
  output logic [1:0]        opnd_bytes,
  output logic              illegal_mode,
  output logic [REG_W-1:0]  rdata
);
  logic [BYTE_W-1:0] dp_page;
  logic [ADDR_W-1:0] ea_next;
  logic              mem_next;
  logic [CNT_W-1:0]  nb_next;
  logic              bad_next;
  logic [REG_W-1:0]  rd_next;
  logic              rsel_zero;

  oeag_dp_reg u_dp (
    .clk(clk), .rst_n(rst_n), .wr_en(dp_wr_en), .wr_data(dp_wr_data), .page(dp_page)
  );

  oeag_ea_calc u_calc (
    .mode(mode), .b0(opnd_b0), .b1(opnd_b1), .page(dp_page),
    .ea(ea_next), .mem(mem_next), .nbytes(nb_next), .bad_mode(bad_next)
  );

  oeag_zero_reg #(.RIDX_W(RIDX_W), .REG_W(REG_W)) u_zr (
    .idx(rsel), .raw(rdata_raw), .value(rd_next), .is_zero_idx(rsel_zero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      eff_addr     <= '0;
      mem_access   <= 1'b0;
      opnd_bytes   <= '0;
      illegal_mode <= 1'b0;
      rdata        <= '0;
    end else begin
      out_valid <= insn_valid;
      if (insn_valid) begin
        eff_addr     <= ea_next;
        mem_access   <= mem_next;
        opnd_bytes   <= nb_next;
        illegal_mode <= bad_next;
        rdata        <= rd_next;
      end
    end
  end
endmodule

// File: rtl/oeag_chk.sv
module oeag_chk #(
  parameter int RIDX_W = 4,
  parameter int REG_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              insn_valid,
  input logic [2:0]        mode,
  input logic [7:0]        opnd_b0,
  input logic [7:0]        opnd_b1,
  input logic              dp_wr_en,
  input logic [7:0]        dp_wr_data,
  input logic [RIDX_W-1:0] rsel,
  input logic              out_valid,
  input logic [15:0]       eff_addr,
  input logic              mem_access,
  input logic [1:0]        opnd_bytes,
  input logic              illegal_mode,
  input logic [REG_W-1:0]  rdata,
  input logic [7:0]        dp_page
);
  p_valid_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    insn_valid |=> out_valid);
  p_valid_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_valid |=> !out_valid);
  p_reg_nomem_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && mode == 3'd1) |=> (!mem_access && eff_addr == 16'h0 && opnd_bytes == 2'd0));
  p_zero_index_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && rsel == '0) |=> (rdata == '0));
  p_page0_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && mode == 3'd2) |=> (eff_addr == {8'h00, $past(opnd_b0)} && mem_access));
  p_dpage_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && mode == 3'd3) |=> (eff_addr == {$past(dp_page), $past(opnd_b0)} && mem_access));
  p_long_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && mode == 3'd4) |=> (eff_addr == {$past(opnd_b0), $past(opnd_b1)} && opnd_bytes == 2'd2));
  p_illegal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && mode > 3'd4) |=> (illegal_mode && !mem_access));
  p_dp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !dp_wr_en |=> $stable(dp_page));
  p_dp_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dp_wr_en |=> (dp_page == $past(dp_wr_data)));
  always_comb begin
    if (!rst_n) begin
      a_reset_r11: assert (!out_valid && dp_page == 8'h00);
    end
  end
endmodule

bind opnd_addr_gen oeag_chk #(.RIDX_W(RIDX_W), .REG_W(REG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .mode(mode),
  .opnd_b0(opnd_b0), .opnd_b1(opnd_b1), .dp_wr_en(dp_wr_en), .dp_wr_data(dp_wr_data),
  .rsel(rsel), .out_valid(out_valid), .eff_addr(eff_addr), .mem_access(mem_access),
  .opnd_bytes(opnd_bytes), .illegal_mode(illegal_mode), .rdata(rdata), .dp_page(dp_page)
);

// File: tb/test_opnd_addr_gen.sv
module test_opnd_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        insn_valid = 1'b0;
  logic [2:0]  mode = '0;
  logic [7:0]  opnd_b0 = '0, opnd_b1 = '0, dp_wr_data = '0;
  logic        dp_wr_en = 1'b0;
  logic [3:0]  rsel = '0;
  logic [7:0]  rdata_raw = '0;
  logic        out_valid, mem_access, illegal_mode;
  logic [15:0] eff_addr;
  logic [1:0]  opnd_bytes;
  logic [7:0]  rdata;

  int n_vec = 0, n_bad = 0;
  logic [7:0] model_dp = 8'h00;
  bit done = 0;

  always #10 clk = ~clk;

  opnd_addr_gen i_opnd_addr_gen (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .mode(mode),
    .opnd_b0(opnd_b0), .opnd_b1(opnd_b1), .dp_wr_en(dp_wr_en), .dp_wr_data(dp_wr_data),
    .rsel(rsel), .rdata_raw(rdata_raw), .out_valid(out_valid), .eff_addr(eff_addr),
    .mem_access(mem_access), .opnd_bytes(opnd_bytes), .illegal_mode(illegal_mode),
    .rdata(rdata)
  );

  // Expected-value functions written from the requirements
  function automatic logic [15:0] exp_addr(input logic [2:0] m, input logic [7:0] b0,
                                           input logic [7:0] b1, input logic [7:0] pg);
    case (m)
      3'd2:    return {8'h00, b0};    // R5
      3'd3:    return {pg, b0};       // R6
      3'd4:    return {b0, b1};       // R7
      default: return 16'h0000;       // R2 R4 R8
    endcase
  endfunction

  function automatic logic [1:0] exp_len(input logic [2:0] m);
    case (m)
      3'd0, 3'd2, 3'd3: return 2'd1;
      3'd4:             return 2'd2;
      default:          return 2'd0;
    endcase
  endfunction

  function automatic string tag(input logic [2:0] m);
    case (m)
      3'd0: return "R4"; 3'd1: return "R2"; 3'd2: return "R5";
      3'd3: return "R6/R9/R10"; 3'd4: return "R7"; default: return "R8";
    endcase
  endfunction

  task automatic apply(input logic [2:0] m, input logic [7:0] b0, input logic [7:0] b1,
                       input logic we, input logic [7:0] wd,
                       input logic [3:0] rs, input logic [7:0] raw);
    logic [15:0] ea_x;
    logic [1:0]  len_x;
    logic        mem_x, ill_x;
    logic [7:0]  rd_x;
    ea_x  = exp_addr(m, b0, b1, model_dp);
    len_x = exp_len(m);
    mem_x = (m == 3'd2 || m == 3'd3 || m == 3'd4);
    ill_x = (m > 3'd4);
    rd_x  = (rs == 4'd0) ? 8'h00 : raw;   // R3
    mode = m; opnd_b0 = b0; opnd_b1 = b1; dp_wr_en = we; dp_wr_data = wd;
    rsel = rs; rdata_raw = raw; insn_valid = 1'b1;
    @(negedge clk);
    insn_valid = 1'b0; dp_wr_en = 1'b0;
    if (we) model_dp = wd;               // R10: visible from next instruction
    n_vec++;
    if (!out_valid || eff_addr !== ea_x || mem_access !== mem_x ||
        opnd_bytes !== len_x || illegal_mode !== ill_x || rdata !== rd_x) begin
      n_bad++;
      $display("FAIL %s/R1/R3 mode=%0d: got v=%b ea=%h mem=%b len=%0d ill=%b rd=%h exp v=1 ea=%h mem=%b len=%0d ill=%b rd=%h",
               tag(m), m, out_valid, eff_addr, mem_access, opnd_bytes, illegal_mode, rdata,
               ea_x, mem_x, len_x, ill_x, rd_x);
    end
  endtask

  task automatic check_idle();
    @(negedge clk);
    n_vec++;
    if (out_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 idle: out_valid=%b expected 0", out_valid);
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R11 reset state
    n_vec++;
    if (out_valid !== 0 || eff_addr !== 0 || mem_access !== 0 || opnd_bytes !== 0 ||
        illegal_mode !== 0 || rdata !== 0) begin
      n_bad++;
      $display("FAIL R11 reset: got v=%b ea=%h mem=%b len=%0d ill=%b rd=%h expected all zero",
               out_valid, eff_addr, mem_access, opnd_bytes, illegal_mode, rdata);
    end
    rst_n = 1'b1;
    @(negedge clk);
    check_idle();                                              // R1
    // R9: page register starts at zero
    apply(3'd3, 8'h5A, 8'h00, 1'b0, 8'h00, 4'd1, 8'h11);
    apply(3'd2, 8'h5A, 8'h00, 1'b0, 8'h00, 4'd2, 8'h22);       // R5
    // R10: write collides with a direct-page instruction
    apply(3'd3, 8'h34, 8'h00, 1'b1, 8'hC7, 4'd0, 8'hFF);       // old page, R3 zero index
    apply(3'd3, 8'h34, 8'h00, 1'b0, 8'h00, 4'd0, 8'hAA);       // new page C7
    check_idle();
    apply(3'd4, 8'h12, 8'h34, 1'b0, 8'h00, 4'd5, 8'h5C);       // R7 high byte first
    apply(3'd4, 8'hFF, 8'hFF, 1'b0, 8'h00, 4'd15, 8'h01);      // R7 top of space
    apply(3'd1, 8'h99, 8'h88, 1'b0, 8'h00, 4'd0, 8'h77);       // R2
    apply(3'd0, 8'h42, 8'h00, 1'b0, 8'h00, 4'd3, 8'h00);       // R4
    apply(3'd5, 8'h10, 8'h20, 1'b0, 8'h00, 4'd1, 8'h33);       // R8
    apply(3'd6, 8'h10, 8'h20, 1'b0, 8'h00, 4'd1, 8'h33);       // R8
    apply(3'd7, 8'h10, 8'h20, 1'b0, 8'h00, 4'd1, 8'h33);       // R8
    apply(3'd3, 8'hFF, 8'h00, 1'b1, 8'h00, 4'd1, 8'h44);       // R6 page still C7
    apply(3'd3, 8'hFF, 8'h00, 1'b0, 8'h00, 4'd1, 8'h44);       // R6 page back to 00
    // constrained random mix
    for (int i = 0; i < 400; i++) begin
      logic [2:0] m;
      m = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 3) != 0) m = 3'($urandom_range(0, 4));
      apply(m, 8'($urandom), 8'($urandom), ($urandom_range(0, 2) == 0), 8'($urandom),
            4'($urandom_range(0, 3) == 0 ? 0 : $urandom), 8'($urandom));
      if ($urandom_range(0, 7) == 0) check_idle();
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule